// File: doc/BRIEF.md
# Full/empty tagged synchronizing memory

A small word-addressed memory in which every word carries one tag bit telling whether the word currently holds a value ("full") or not ("empty"). Two requesters share the memory through separate valid/ready ports. Each port can issue four kinds of access:

- Plain accesses read or write the data and never look at or change the tag.
- A synchronizing read waits for a full word. It then returns the data and leaves the word empty.
- A synchronizing write waits for an empty word. It then stores the data and leaves the word full.

The tag test, the data access and the tag flip take place in the same clock cycle, so no other access can come between them.

A request whose tag test fails stays pending. Ready stays low for as long as the requester holds valid, with no timeout. Such a blocked request never holds up the other port. The arbiter only considers requests that can complete in the current cycle, and it grants at most one of them per cycle, in round-robin order. A tag-clear command sweeps the tag array one word per cycle and stalls both ports while the sweep runs. This makes the block a hardware producer/consumer handshake at word granularity, for example as a mailbox between two engines.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is empty, init_busy is low, and a port never shows ready while its valid is low.
- R2: A plain read (op 0) returns the stored word, and a plain write (op 1) stores its data. Both complete regardless of the tag and leave the tag unchanged.
- R3: A synchronizing write (op 3) to an empty word completes with ready high in the same cycle it is presented. It stores the data and leaves the word full.
- R4: A synchronizing write to a full word holds ready low and leaves the stored data untouched.
- R5: A synchronizing read (op 2) of a full word completes with ready high in the same cycle it is presented. p*_rdata carries the word in that cycle, and the word is left empty.
- R6: A synchronizing read of an empty word holds ready low until a write fills the word.
- R7: A high init_req while the block is idle starts a sweep. init_busy is high for exactly 2**AW cycles, starting at the next clock edge. Ready is low on both ports in the request cycle and throughout the sweep. Every tag is empty afterwards.
- R8: At most one port is ready in any cycle. When both ports can complete, the grant alternates, starting with port 0 after reset.
- R9: A blocked request on one port does not delay a request on the other port that can complete; that request completes in the same cycle.
- R10: When a synchronizing read and a synchronizing write target the same empty word in one cycle, the write completes first and the read completes in the following cycle with the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Request a sweep that clears all tags to empty |
| init_busy | output | 1 | Tag sweep in progress |
| p0_valid | input | 1 | Port 0 request valid |
| p0_op | input | 2 | Port 0 access kind: 0 plain read, 1 plain write, 2 sync read, 3 sync write |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_ready | output | 1 | Port 0 request completes this cycle |
| p0_rdata | output | DW | Port 0 read data, meaningful when ready is high on a read |
| p1_valid | input | 1 | Port 1 request valid |
| p1_op | input | 2 | Port 1 access kind, same encoding as p0_op |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_ready | output | 1 | Port 1 request completes this cycle |
| p1_rdata | output | DW | Port 1 read data |

## Verification
The bench goes after the tag state left behind by each access, and it always observes that state through a later access's ready:

- A plain write that disturbed the tag would let a following sync read pass where it must block.
- A sync write that ignored a full tag would overwrite data that a later plain read exposes.

Other cases cover the arbiter and the sweep:

- The same-word read/write collision would show up as both ports ready together, or as the reader returning stale data.
- An arbiter without the rotation would hand port 0 every grant.
- The sweep is timed cycle by cycle, so an off-by-one counter shows up as a wrong busy length. Ready leaking through during the sweep is also caught.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [1:0] {
    FE_RD  = 2'd0,
    FE_WR  = 2'd1,
    FE_SRD = 2'd2,
    FE_SWR = 2'd3
  } fe_op_e;

  // tag test: sync read needs full, sync write needs empty, plain always passes
  function automatic logic fe_can_go(fe_op_e op, logic tag);
    case (op)
      FE_SRD:  return tag;
      FE_SWR:  return !tag;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic fe_writes_data(fe_op_e op);
    return (op == FE_WR) || (op == FE_SWR);
  endfunction

  function automatic logic fe_is_sync(fe_op_e op);
    return (op == FE_SRD) || (op == FE_SWR);
  endfunction

endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
  parameter int AW  = 4,
  parameter int NRD = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   init_start,
  input  logic                   upd_en,
  input  logic [AW-1:0]          upd_addr,
  input  logic                   upd_val,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0]         rd_tag,
  output logic                   busy,
  output logic [(1<<AW)-1:0]     tags_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DEPTH-1:0] tags_q, tags_d;
  logic             busy_q, busy_d;
  logic [AW-1:0]    cnt_q, cnt_d;

  // sweep control
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q + AW'(1);
      if (cnt_q == LAST) busy_d = 1'b0;
    end else if (init_start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  // tag next state: sweep has precedence, access updates otherwise
  always_comb begin
    tags_d = tags_q;
    if (busy_q)      tags_d[cnt_q]    = 1'b0;
    else if (upd_en) tags_d[upd_addr] = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags_q <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tags_q <= tags_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_look
    assign rd_tag[g] = tags_q[rd_addr[g]];
  end

  assign busy   = busy_q;
  assign tags_o = tags_q;
endmodule

// File: rtl/fe_word_store.sv
module fe_word_store #(
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter int NRD = 2
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [NRD-1:0][AW-1:0] rd_addr,
  output logic [NRD-1:0][DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // data array carries no reset; contents are defined by writes only
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem_q[rd_addr[g]];
  end
endmodule

// File: rtl/fe_rr_arb.sv
module fe_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] prio_q, prio_d;
  logic          found;

  always_comb begin
    grant  = '0;
    found  = 1'b0;
    prio_d = prio_q;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (int'(prio_q) + off) % N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
        prio_d     = PW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prio_q <= '0;
    else if (|req) prio_q <= prio_d;
  end
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req,
  output logic          init_busy,
  input  logic          p0_valid,
  input  logic [1:0]    p0_op,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic          p0_ready,
  output logic [DW-1:0] p0_rdata,
  input  logic          p1_valid,
  input  logic [1:0]    p1_op,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic          p1_ready,
  output logic [DW-1:0] p1_rdata
);
  localparam int NP    = 2;
  localparam int DEPTH = 1 << AW;

  logic [NP-1:0]         vld, req, grant, tag_hit;
  fe_op_e                op [NP];
  logic [NP-1:0][AW-1:0] addr;
  logic [NP-1:0][DW-1:0] wdat, rdat;
  logic [DEPTH-1:0]      tag_vec;
  logic                  sweep, stall;
  logic                  upd_en, upd_val, wr_en;
  logic [AW-1:0]         acc_addr;
  logic [DW-1:0]         acc_data;

  assign vld   = {p1_valid, p0_valid};
  assign op[0] = fe_op_e'(p0_op);
  assign op[1] = fe_op_e'(p1_op);
  assign addr  = {p1_addr, p0_addr};
  assign wdat  = {p1_wdata, p0_wdata};

  assign stall = sweep | init_req;

  fe_tag_array #(.AW(AW), .NRD(NP)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_start (init_req),
    .upd_en     (upd_en),
    .upd_addr   (acc_addr),
    .upd_val    (upd_val),
    .rd_addr    (addr),
    .rd_tag     (tag_hit),
    .busy       (sweep),
    .tags_o     (tag_vec)
  );

  fe_word_store #(.AW(AW), .DW(DW), .NRD(NP)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (acc_addr),
    .wr_data (acc_data),
    .rd_addr (addr),
    .rd_data (rdat)
  );

  // a request competes only when its tag test passes this cycle
  always_comb begin
    for (int i = 0; i < NP; i++)
      req[i] = vld[i] & ~stall & fe_can_go(op[i], tag_hit[i]);
  end

  fe_rr_arb #(.N(NP)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant)
  );

  // winning access: data write and tag flip in the same edge
  always_comb begin
    upd_en   = 1'b0;
    upd_val  = 1'b0;
    wr_en    = 1'b0;
    acc_addr = '0;
    acc_data = '0;
    for (int i = 0; i < NP; i++) begin
      if (grant[i]) begin
        acc_addr = addr[i];
        acc_data = wdat[i];
        wr_en    = fe_writes_data(op[i]);
        upd_en   = fe_is_sync(op[i]);
        upd_val  = (op[i] == FE_SWR);
      end
    end
  end

  assign init_busy = sweep;
  assign p0_ready  = grant[0];
  assign p1_ready  = grant[1];
  assign p0_rdata  = rdat[0];
  assign p1_rdata  = rdat[1];
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int AW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_busy,
  input logic               p0_valid,
  input logic [1:0]         p0_op,
  input logic [AW-1:0]      p0_addr,
  input logic               p0_ready,
  input logic               p1_valid,
  input logic [1:0]         p1_op,
  input logic [AW-1:0]      p1_addr,
  input logic               p1_ready,
  input logic [(1<<AW)-1:0] tags
);
  AST_P0_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    p0_ready |-> p0_valid); // R1
  AST_P1_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    p1_ready |-> p1_valid); // R1
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(p0_ready && p1_ready)); // R8
  AST_SWEEP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (!p0_ready && !p1_ready)); // R7
  AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> (tags == '0)); // R7
  AST_SWR_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ready && p0_op == 2'd3) |-> !tags[p0_addr]); // R4
  AST_SRD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_ready && p1_op == 2'd2) |-> tags[p1_addr]); // R6
  AST_SWR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_ready && p1_op == 2'd3) |=> tags[$past(p1_addr)]); // R3
  AST_SRD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ready && p0_op == 2'd2) |=> !tags[$past(p0_addr)]); // R5
  AST_PLAIN_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_ready && !p0_op[1]) |=> (tags[$past(p0_addr)] == $past(tags[p0_addr]))); // R2
endmodule

bind fe_sync_mem fe_sync_mem_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init_busy (init_busy),
  .p0_valid  (p0_valid),
  .p0_op     (p0_op),
  .p0_addr   (p0_addr),
  .p0_ready  (p0_ready),
  .p1_valid  (p1_valid),
  .p1_op     (p1_op),
  .p1_addr   (p1_addr),
  .p1_ready  (p1_ready),
  .tags      (tag_vec)
);

// File: tb/fe_sync_mem_bench.sv
`timescale 1ns/1ps
module fe_sync_mem_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NV = 17;

  typedef struct packed {
    logic [3:0]  rq;
    logic        v0; logic [1:0] op0; logic [3:0] a0; logic [15:0] d0;
    logic        v1; logic [1:0] op1; logic [3:0] a1; logic [15:0] d1;
    logic        r0; logic r1;
    logic [15:0] x0; logic [15:0] x1;
  } vec_t;

  // op: 0 plain read, 1 plain write, 2 sync read, 3 sync write
  localparam vec_t VECS [NV] = '{
    '{4'd3, 1'b1,2'd3,4'd1,16'h1111, 1'b0,2'd0,4'd0,16'h0, 1'b1,1'b0, 16'h0,16'h0},    // R3
    '{4'd4, 1'b1,2'd3,4'd1,16'h2222, 1'b0,2'd0,4'd0,16'h0, 1'b0,1'b0, 16'h0,16'h0},    // R4
    '{4'd4, 1'b1,2'd0,4'd1,16'h0,    1'b0,2'd0,4'd0,16'h0, 1'b1,1'b0, 16'h1111,16'h0}, // R4
    '{4'd10,1'b1,2'd2,4'd2,16'h0,    1'b1,2'd3,4'd2,16'h3333, 1'b0,1'b1, 16'h0,16'h0}, // R10 R9
    '{4'd10,1'b1,2'd2,4'd2,16'h0,    1'b0,2'd0,4'd0,16'h0, 1'b1,1'b0, 16'h3333,16'h0}, // R10 R5
    '{4'd6, 1'b1,2'd2,4'd2,16'h0,    1'b0,2'd0,4'd0,16'h0, 1'b0,1'b0, 16'h0,16'h0},    // R6
    '{4'd2, 1'b1,2'd1,4'd2,16'h4444, 1'b0,2'd0,4'd0,16'h0, 1'b1,1'b0, 16'h0,16'h0},    // R2
    '{4'd2, 1'b1,2'd2,4'd2,16'h0,    1'b0,2'd0,4'd0,16'h0, 1'b0,1'b0, 16'h0,16'h0},    // R2
    '{4'd2, 1'b1,2'd0,4'd2,16'h0,    1'b0,2'd0,4'd0,16'h0, 1'b1,1'b0, 16'h4444,16'h0}, // R2
    '{4'd8, 1'b1,2'd0,4'd1,16'h0,    1'b1,2'd0,4'd2,16'h0, 1'b0,1'b1, 16'h0,16'h4444}, // R8
    '{4'd8, 1'b1,2'd0,4'd1,16'h0,    1'b1,2'd0,4'd2,16'h0, 1'b1,1'b0, 16'h1111,16'h0}, // R8
    '{4'd8, 1'b1,2'd0,4'd1,16'h0,    1'b1,2'd0,4'd2,16'h0, 1'b0,1'b1, 16'h0,16'h4444}, // R8
    '{4'd2, 1'b1,2'd1,4'd1,16'h5555, 1'b0,2'd0,4'd0,16'h0, 1'b1,1'b0, 16'h0,16'h0},    // R2
    '{4'd2, 1'b0,2'd0,4'd0,16'h0,    1'b1,2'd3,4'd1,16'h6666, 1'b0,1'b0, 16'h0,16'h0}, // R2
    '{4'd5, 1'b0,2'd0,4'd0,16'h0,    1'b1,2'd2,4'd1,16'h0, 1'b0,1'b1, 16'h0,16'h5555}, // R5
    '{4'd3, 1'b0,2'd0,4'd0,16'h0,    1'b1,2'd3,4'd1,16'h6666, 1'b0,1'b1, 16'h0,16'h0}, // R3
    '{4'd5, 1'b1,2'd2,4'd1,16'h0,    1'b0,2'd0,4'd0,16'h0, 1'b1,1'b0, 16'h6666,16'h0}  // R5
  };

  logic clk, rst_n, init_req, init_busy;
  logic p0_valid, p0_ready, p1_valid, p1_ready;
  logic [1:0] p0_op, p1_op;
  logic [AW-1:0] p0_addr, p1_addr;
  logic [DW-1:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  fe_sync_mem #(.AW(AW), .DW(DW)) u_fe_sync_mem (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(logic v0, logic [1:0] o0, logic [3:0] a0, logic [15:0] d0,
                       logic v1, logic [1:0] o1, logic [3:0] a1, logic [15:0] d1);
    @(negedge clk);
    p0_valid = v0; p0_op = o0; p0_addr = a0; p0_wdata = d0;
    p1_valid = v1; p1_op = o1; p1_addr = a1; p1_wdata = d1;
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; init_req = 1'b0;
    p0_valid = 0; p0_op = 0; p0_addr = 0; p0_wdata = 0;
    p1_valid = 0; p1_op = 0; p1_addr = 0; p1_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    drive(0,0,0,0, 0,0,0,0);
    check("R1 p0_ready idle", p0_ready, 0);
    check("R1 p1_ready idle", p1_ready, 0);
    check("R1 init_busy", init_busy, 0);
    drive(1,2'd2,0,0, 0,0,0,0);
    check("R1 tag empty after reset", p0_ready, 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].v0, VECS[k].op0, VECS[k].a0, VECS[k].d0,
            VECS[k].v1, VECS[k].op1, VECS[k].a1, VECS[k].d1);
      check($sformatf("R%0d vec%0d p0_ready", VECS[k].rq, k), p0_ready, VECS[k].r0);
      check($sformatf("R%0d vec%0d p1_ready", VECS[k].rq, k), p1_ready, VECS[k].r1);
      if (VECS[k].r0 && !VECS[k].op0[0])
        check($sformatf("R%0d vec%0d p0_rdata", VECS[k].rq, k), p0_rdata, VECS[k].x0);
      if (VECS[k].r1 && !VECS[k].op1[0])
        check($sformatf("R%0d vec%0d p1_rdata", VECS[k].rq, k), p1_rdata, VECS[k].x1);
    end

    // R7: fill two words, then sweep
    drive(1,2'd3,4'd3,16'h7777, 0,0,0,0);
    check("R7 fill a3", p0_ready, 1);
    drive(0,0,0,0, 1,2'd3,4'd5,16'h8888);
    check("R7 fill a5", p1_ready, 1);
    drive(1,2'd0,4'd3,0, 0,0,0,0);
    init_req = 1'b1;
    #0.5;
    check("R7 ready low on request cycle", p0_ready, 0);
    @(negedge clk);
    init_req = 1'b0;
    #1;
    begin
      int busy_cycles;
      busy_cycles = 0;
      while (init_busy && busy_cycles < 40) begin
        busy_cycles++;
        if (p0_ready) check("R7 ready during sweep", p0_ready, 0);
        @(negedge clk);
        #1;
      end
      check("R7 sweep length", busy_cycles, 1 << AW);
    end
    drive(1,2'd2,4'd3,0, 0,0,0,0);
    check("R7 a3 empty after sweep", p0_ready, 0);
    drive(0,0,0,0, 1,2'd3,4'd5,16'h9999);
    check("R7 a5 empty after sweep", p1_ready, 1);

    // R9: port 0 blocked on empty word, port 1 plain read proceeds
    drive(1,2'd2,4'd7,0, 1,2'd0,4'd5,0);
    check("R9 p0 blocked", p0_ready, 0);
    check("R9 p1 served", p1_ready, 1);
    check("R9 p1 data", p1_rdata, 16'h9999);
    drive(0,0,0,0, 0,0,0,0);

    done = 1;
    finish_run();
  end
endmodule